// File: doc/BRIEF.md
# SECDED Guard with Fault Injection and Error Capture

This block sits between one requester and one memory port. Write beats pass straight through. On the way the block adds single-error-correct, double-error-detect check bits computed from the data. On request it flips chosen data bits before they are stored, so that software can test its error handling. Read beats coming back from the memory are checked. A single-bit error is corrected in the returned data. A multi-bit error is passed on unchanged and marked with a flag.

Every detected error sets its own sticky status bit. The single-bit class and the multi-bit class each have a capture bank. A bank records the first faulting read of its class with its full context: address, raw data, syndrome, failing bit, access size, write/read flag, requester ID and privilege. It holds that record until software clears the status bit. All configuration and capture state sit in a small word-addressed register file.

Both data paths are valid/ready streams with no storage, and both are combinational. On the write side, `w_ready` equals `mw_ready`, and a beat counts as accepted on a clock edge where `w_valid` and `mw_ready` are both high. On the read side, `mr_ready` equals `r_ready`, and a beat counts as consumed on an edge where `mr_valid` and `r_ready` are both high. Back-pressure from either consumer therefore stalls the matching producer in the same cycle, and the payload must stay stable while valid is high and ready is low.

Top module: `ecc_guard`

## Requirements
- R1: Write path pass-through. `mw_valid` follows `w_valid`, `w_ready` follows `mw_ready`, and `mw_addr` follows `w_addr`. `mw_code` is the code of the uncorrupted `w_data`, built as follows. Data bit j takes the (j+1)-th integer from 3 upward that is not a power of two. `mw_code[6:0]` is the XOR of those numbers over all set data bits. `mw_code[7]` is the XOR of all data bits and of `mw_code[6:0]`.
- R2: When no injection is armed, `mw_data` equals `w_data`. Reading that word back returns it unchanged, with `r_uncorr` low and no status bit set.
- R3: Control register (index 0) fields: bit0 check enable, bit1 one-shot single, bit2 one-shot multi, bit3 continuous single, bit4 continuous multi, bits[15:8] first position A, bits[23:16] second position B. A single injection inverts data bit A. A multi injection inverts bits A and B, and it takes precedence when both kinds are armed. A position at or above the data width inverts nothing.
- R4: A one-shot bit corrupts only the next accepted write, then reads back as 0. The following write is stored uncorrupted.
- R5: A continuous bit corrupts every accepted write for as long as it stays set, and it never clears itself.
- R6: When checking is enabled and a consumed read beat holds a single-bit error, `r_data` is the corrected data and `r_uncorr` is low. Status (index 1) bit0 reads 1 from the next cycle on.
- R7: When a consumed read beat holds a multi-bit error, `r_data` is the raw data and `r_uncorr` is high. Status bit1 reads 1 from the next cycle on.
- R8: The single bank sits at indices 2–5 (address, info, data[31:0], data[63:32]) and the multi bank at indices 6–9 in the same order. The info word holds: [7:0] syndrome = {overall parity mismatch, recomputed XOR stored code[6:0]}, [15:8] failing data bit (0xFF if the error is not in data; always 0 in the multi bank), [17:16] size code (3 for 64-bit, 2 for 32-bit), [18] write flag from `mr_rmw`, [19] privilege, [27:20] requester ID.
- R9: A bank keeps its first error while its status bit is set, and later errors of that class do not overwrite it. Writing 1 to a status bit clears it, and the next error of that class is then captured.
- R10: With check enable 0, read data passes through uncorrected, `r_uncorr` stays low, and no status bit is set.
- R11: After reset the control register reads 0x00000001 (checking on, nothing armed) and the status register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| w_valid | input | 1 | Write beat valid |
| w_ready | output | 1 | Write beat ready |
| w_addr | input | AW | Write address |
| w_data | input | DW | Write data |
| mw_valid | output | 1 | Memory write valid |
| mw_ready | input | 1 | Memory write ready |
| mw_addr | output | AW | Memory write address |
| mw_data | output | DW | Stored data, possibly corrupted |
| mw_code | output | CW | Check bits of the uncorrupted data |
| mr_valid | input | 1 | Memory read beat valid |
| mr_ready | output | 1 | Memory read beat ready |
| mr_addr | input | AW | Address of the read beat |
| mr_data | input | DW | Raw data read from memory |
| mr_code | input | CW | Check bits read from memory |
| mr_id | input | IW | Requester ID of the access |
| mr_priv | input | 1 | Privilege of the access |
| mr_rmw | input | 1 | 1 when the read serves a write access |
| r_valid | output | 1 | Read result valid |
| r_ready | input | 1 | Read result ready |
| r_data | output | DW | Checked (corrected) read data |
| r_uncorr | output | 1 | Multi-bit error in the current beat |

## Verification
The assertions rely on three things about the inputs: a control register write never falls in the same cycle as an accepted write beat, a status clear never coincides with a consumed erroneous read, and `mr_code` only ever holds what the block itself produced for that address. The stimulus keeps to these. Register accesses and stream beats go in separate cycles. The bench memory stores exactly `mw_data` and `mw_code`, and returns them on reads. Injection positions are chosen in advance, so every corrupted word carries exactly the one or two flips the test expects.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;
  localparam int MAXW = 128;

  // Hamming bits needed for dw data bits (without the overall parity bit)
  function automatic int ham_bits(input int dw);
    for (int p = 2; p < 12; p++)
      if ((1 << p) >= dw + p + 1) return p;
    return 12;
  endfunction

  function automatic int code_bits(input int dw);
    return ham_bits(dw) + 1;
  endfunction

  // Codeword position of data bit j: j-th non-power-of-two from 3 upward
  function automatic int data_pos(input int j);
    int cnt;
    cnt = 0;
    for (int k = 3; k < 4 * MAXW; k++) begin
      if ((k & (k - 1)) != 0) begin
        if (cnt == j) return k;
        cnt++;
      end
    end
    return 0;
  endfunction

  // Data bits covered by Hamming check bit i
  function automatic logic [MAXW-1:0] col_mask(input int i);
    logic [MAXW-1:0] m;
    m = '0;
    for (int j = 0; j < MAXW; j++)
      m[j] = ((data_pos(j) >> i) & 1) != 0;
    return m;
  endfunction
endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc import ecc_guard_pkg::*; #(
  parameter int DW = 64,
  localparam int CW = code_bits(DW),
  localparam int HB = CW - 1
) (
  input  logic [DW-1:0] data,
  output logic [CW-1:0] code
);
  logic [HB-1:0] ham;

  for (genvar i = 0; i < HB; i++) begin : g_col
    localparam logic [MAXW-1:0] M = col_mask(i);
    assign ham[i] = ^(data & M[DW-1:0]);
  end

  // overall parity makes the whole codeword even
  assign code = {^{data, ham}, ham};
endmodule

// File: rtl/ecc_wr_inject.sv
module ecc_wr_inject #(
  parameter int DW = 64,
  parameter int PW = 8
) (
  input  logic          arm_single,
  input  logic          arm_multi,
  input  logic [PW-1:0] pos_a,
  input  logic [PW-1:0] pos_b,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] flip;

  for (genvar j = 0; j < DW; j++) begin : g_bit
    assign flip[j] = ((arm_single || arm_multi) && (pos_a == PW'(j)))
                   || (arm_multi && (pos_b == PW'(j)));
  end

  assign dout = din ^ flip;
endmodule

// File: rtl/ecc_rd_check.sv
module ecc_rd_check import ecc_guard_pkg::*; #(
  parameter int DW = 64,
  localparam int CW = code_bits(DW),
  localparam int HB = CW - 1
) (
  input  logic          en,
  input  logic [DW-1:0] data,
  input  logic [CW-1:0] code,
  output logic [DW-1:0] dout,
  output logic          single,
  output logic          multi,
  output logic [CW-1:0] syndrome,
  output logic [7:0]    bitpos
);
  logic [CW-1:0] recalc;
  logic [HB-1:0] syn_h;
  logic          odd;
  logic [DW-1:0] hit;
  logic          unused_recalc_top;

  ecc_secded_enc #(.DW(DW)) u_recalc (.data(data), .code(recalc));

  assign unused_recalc_top = recalc[HB];
  assign syn_h    = recalc[HB-1:0] ^ code[HB-1:0];
  assign odd      = ^{data, code};
  assign single   = en && odd;
  assign multi    = en && !odd && (syn_h != '0);
  assign syndrome = {odd, syn_h};

  for (genvar j = 0; j < DW; j++) begin : g_hit
    localparam int PJ = data_pos(j);
    assign hit[j] = (syn_h == HB'(PJ));
  end

  assign dout = single ? (data ^ hit) : data;

  always_comb begin
    bitpos = 8'hFF;
    for (int j = 0; j < DW; j++)
      if (hit[j]) bitpos = 8'(j);
  end
endmodule

// File: rtl/ecc_capture_bank.sv
module ecc_capture_bank #(
  parameter int AW = 16,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clear,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [31:0]   info,
  output logic          flag,
  output logic [AW-1:0] q_addr,
  output logic [DW-1:0] q_data,
  output logic [31:0]   q_info
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      q_addr <= '0;
      q_data <= '0;
      q_info <= '0;
    end else if (load && (!flag || clear)) begin
      flag   <= 1'b1;
      q_addr <= addr;
      q_data <= data;
      q_info <= info;
    end else if (clear) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_guard.sv
module ecc_guard import ecc_guard_pkg::*; #(
  parameter int DW = 64,
  parameter int AW = 16,
  parameter int IW = 4,
  localparam int CW = code_bits(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          w_valid,
  output logic          w_ready,
  input  logic [AW-1:0] w_addr,
  input  logic [DW-1:0] w_data,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [DW-1:0] mw_data,
  output logic [CW-1:0] mw_code,
  input  logic          mr_valid,
  output logic          mr_ready,
  input  logic [AW-1:0] mr_addr,
  input  logic [DW-1:0] mr_data,
  input  logic [CW-1:0] mr_code,
  input  logic [IW-1:0] mr_id,
  input  logic          mr_priv,
  input  logic          mr_rmw,
  output logic          r_valid,
  input  logic          r_ready,
  output logic [DW-1:0] r_data,
  output logic          r_uncorr
);
  localparam int POS_W = 8;
  localparam logic [1:0] SIZE_CODE = (DW == 64) ? 2'd3 : 2'd2;

  // control state
  logic             check_en, os_s, os_m, ct_s, ct_m;
  logic [POS_W-1:0] pos_a, pos_b;
  logic             ctrl_we, stat_we, w_fire, r_fire;
  logic             unused_wbits;

  assign ctrl_we = reg_we && (reg_addr == 4'd0);
  assign stat_we = reg_we && (reg_addr == 4'd1);
  assign w_fire  = w_valid && mw_ready;
  assign r_fire  = mr_valid && r_ready;
  assign unused_wbits = ^{reg_wdata[31:24], reg_wdata[7:5]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      check_en <= 1'b1;
      os_s     <= 1'b0;
      os_m     <= 1'b0;
      ct_s     <= 1'b0;
      ct_m     <= 1'b0;
      pos_a    <= '0;
      pos_b    <= '0;
    end else if (ctrl_we) begin
      check_en <= reg_wdata[0];
      os_s     <= reg_wdata[1];
      os_m     <= reg_wdata[2];
      ct_s     <= reg_wdata[3];
      ct_m     <= reg_wdata[4];
      pos_a    <= reg_wdata[15:8];
      pos_b    <= reg_wdata[23:16];
    end else if (w_fire) begin
      os_s <= 1'b0;
      os_m <= 1'b0;
    end
  end

  // write stream
  assign mw_valid = w_valid;
  assign w_ready  = mw_ready;
  assign mw_addr  = w_addr;

  ecc_wr_inject #(.DW(DW), .PW(POS_W)) u_inject (
    .arm_single(os_s || ct_s),
    .arm_multi (os_m || ct_m),
    .pos_a     (pos_a),
    .pos_b     (pos_b),
    .din       (w_data),
    .dout      (mw_data)
  );

  ecc_secded_enc #(.DW(DW)) u_encode (.data(w_data), .code(mw_code));

  // read stream
  logic          err_s, err_m;
  logic [CW-1:0] syn;
  logic [7:0]    fail_bit;

  ecc_rd_check #(.DW(DW)) u_check (
    .en      (check_en),
    .data    (mr_data),
    .code    (mr_code),
    .dout    (r_data),
    .single  (err_s),
    .multi   (err_m),
    .syndrome(syn),
    .bitpos  (fail_bit)
  );

  assign r_valid  = mr_valid;
  assign mr_ready = r_ready;
  assign r_uncorr = mr_valid && err_m;

  // capture banks: index 0 single, index 1 multi
  logic [1:0]    flag, bank_load, bank_clr;
  logic [31:0]   bank_info [2];
  logic [AW-1:0] cap_addr  [2];
  logic [DW-1:0] cap_data  [2];
  logic [31:0]   cap_info  [2];
  logic [63:0]   cap_wide  [2];

  assign bank_load = {r_fire && err_m, r_fire && err_s};
  assign bank_clr  = {stat_we && reg_wdata[1], stat_we && reg_wdata[0]};
  assign bank_info[0] = {4'b0, 8'(mr_id), mr_priv, mr_rmw, SIZE_CODE, fail_bit, 8'(syn)};
  assign bank_info[1] = {4'b0, 8'(mr_id), mr_priv, mr_rmw, SIZE_CODE, 8'h00, 8'(syn)};

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ecc_capture_bank #(.AW(AW), .DW(DW)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (bank_load[b]),
      .clear (bank_clr[b]),
      .addr  (mr_addr),
      .data  (mr_data),
      .info  (bank_info[b]),
      .flag  (flag[b]),
      .q_addr(cap_addr[b]),
      .q_data(cap_data[b]),
      .q_info(cap_info[b])
    );
    assign cap_wide[b] = 64'(cap_data[b]);
  end

  // register read
  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = {8'b0, pos_b, pos_a, 3'b0, ct_m, ct_s, os_m, os_s, check_en};
      4'd1:    reg_rdata = {30'b0, flag};
      4'd2:    reg_rdata = 32'(cap_addr[0]);
      4'd3:    reg_rdata = cap_info[0];
      4'd4:    reg_rdata = cap_wide[0][31:0];
      4'd5:    reg_rdata = cap_wide[0][63:32];
      4'd6:    reg_rdata = 32'(cap_addr[1]);
      4'd7:    reg_rdata = cap_info[1];
      4'd8:    reg_rdata = cap_wide[1][31:0];
      4'd9:    reg_rdata = cap_wide[1][63:32];
      default: reg_rdata = 32'b0;
    endcase
  end
endmodule

// File: rtl/ecc_guard_checker.sv
module ecc_guard_checker #(
  parameter int DW = 64,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          w_valid,
  input logic          mw_ready,
  input logic [DW-1:0] w_data,
  input logic [DW-1:0] mw_data,
  input logic          reg_we,
  input logic [3:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          os_s,
  input logic          os_m,
  input logic          ct_s,
  input logic          ct_m,
  input logic          check_en,
  input logic          s_flag,
  input logic          m_flag,
  input logic [AW-1:0] s_addr,
  input logic          mr_valid,
  input logic          r_ready,
  input logic          r_uncorr
);
  assert_oneshot_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && mw_ready && (os_s || os_m) && !(reg_we && reg_addr == 4'd0)) |=> (!os_s && !os_m));

  assert_idle_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && !os_s && !os_m && !ct_s && !ct_m) |-> (mw_data == w_data));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_flag && !(reg_we && reg_addr == 4'd1 && reg_wdata[0])) |=> s_flag);

  assert_capture_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_flag && !(reg_we && reg_addr == 4'd1 && reg_wdata[0])) |=> $stable(s_addr));

  assert_flag_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_flag) |-> $past(mr_valid && r_ready));

  assert_multi_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_valid && r_ready && r_uncorr) |=> m_flag);

  assert_uncorr_needs_check_R10: assert property (@(posedge clk) disable iff (!rst_n)
    r_uncorr |-> check_en);
endmodule

bind ecc_guard ecc_guard_checker #(.DW(DW), .AW(AW)) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .w_valid  (w_valid),
  .mw_ready (mw_ready),
  .w_data   (w_data),
  .mw_data  (mw_data),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .os_s     (os_s),
  .os_m     (os_m),
  .ct_s     (ct_s),
  .ct_m     (ct_m),
  .check_en (check_en),
  .s_flag   (flag[0]),
  .m_flag   (flag[1]),
  .s_addr   (cap_addr[0]),
  .mr_valid (mr_valid),
  .r_ready  (r_ready),
  .r_uncorr (r_uncorr)
);

// File: tb/ecc_guard_test.sv
module ecc_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        w_valid = 1'b0, w_ready;
  logic [15:0] w_addr = '0;
  logic [63:0] w_data = '0;
  logic        mw_valid, mw_ready = 1'b1;
  logic [15:0] mw_addr;
  logic [63:0] mw_data;
  logic [7:0]  mw_code;
  logic        mr_valid = 1'b0, mr_ready;
  logic [15:0] mr_addr = '0;
  logic [63:0] mr_data = '0;
  logic [7:0]  mr_code = '0;
  logic [3:0]  mr_id = '0;
  logic        mr_priv = 1'b0, mr_rmw = 1'b0;
  logic        r_valid, r_ready = 1'b1;
  logic [63:0] r_data;
  logic        r_uncorr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [63:0] mem_d [16];
  logic [7:0]  mem_c [16];

  always #5 clk = ~clk;

  ecc_guard uut (.*);

  always @(posedge clk)
    if (mw_valid && mw_ready) begin
      mem_d[mw_addr[3:0]] <= mw_data;
      mem_c[mw_addr[3:0]] <= mw_code;
    end

  function automatic int bpos(input int j);
    int cnt = 0;
    for (int k = 3; k < 256; k++)
      if ((k & (k - 1)) != 0) begin
        if (cnt == j) return k;
        cnt++;
      end
    return 0;
  endfunction

  function automatic logic [7:0] exp_code(input logic [63:0] d);
    logic [6:0] h = '0;
    for (int j = 0; j < 64; j++)
      if (d[j]) h ^= 7'(bpos(j));
    return {(^d) ^ (^h), h};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic mem_write(input int a, input logic [63:0] d);
    @(negedge clk);
    w_valid = 1'b1; w_addr = 16'(a); w_data = d;
    @(negedge clk);
    w_valid = 1'b0;
  endtask

  task automatic mem_read(input int a, input bit rmw, input logic [3:0] id, input bit priv,
                          output logic [63:0] d, output logic u);
    @(negedge clk);
    mr_valid = 1'b1; mr_addr = 16'(a); mr_data = mem_d[a]; mr_code = mem_c[a];
    mr_rmw = rmw; mr_id = id; mr_priv = priv;
    #1 d = r_data; u = r_uncorr;
    @(negedge clk);
    mr_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    reg_read(4'd0, v); chk("R11 ctrl after reset", 64'(v), 64'h1);
    reg_read(4'd1, v); chk("R11 status after reset", 64'(v), 64'h0);
  endtask

  task automatic t_clean;
    logic [63:0] d; logic u; logic [31:0] v;
    logic [63:0] val = 64'hDEAD_BEEF_0123_4567;
    @(negedge clk);
    w_valid = 1'b1; w_addr = 16'd2; w_data = val; mw_ready = 1'b0;
    #1 chk("R1 back-pressure w_ready", 64'(w_ready), 64'h0);
    chk("R1 mw_addr", 64'(mw_addr), 64'h2);
    chk("R1 check bits", 64'(mw_code), 64'(exp_code(val)));
    mw_ready = 1'b1;
    @(negedge clk);
    w_valid = 1'b0;
    chk("R2 stored clean", mem_d[2], val);
    mem_read(2, 1'b0, 4'd1, 1'b0, d, u);
    chk("R2 read data", d, val);
    chk("R2 no uncorr", 64'(u), 64'h0);
    reg_read(4'd1, v); chk("R2 status clean", 64'(v), 64'h0);
  endtask

  task automatic t_single_oneshot;
    logic [63:0] d; logic u; logic [31:0] v;
    logic [63:0] val = 64'h0F0F_1234_5678_9ABC;
    reg_write(4'd0, 32'h0000_0503);
    mem_write(3, val);
    reg_read(4'd0, v); chk("R4 one-shot self-clears", 64'(v), 64'h0501);
    chk("R3 single flip at A", mem_d[3], val ^ (64'h1 << 5));
    mem_read(3, 1'b0, 4'd9, 1'b1, d, u);
    chk("R6 corrected data", d, val);
    chk("R6 no uncorr", 64'(u), 64'h0);
    reg_read(4'd1, v); chk("R6 single status", 64'(v), 64'h1);
    reg_read(4'd2, v); chk("R8 single addr", 64'(v), 64'h3);
    reg_read(4'd3, v);
    chk("R8 single info", 64'(v),
        64'({4'b0, 8'd9, 1'b1, 1'b0, 2'd3, 8'd5, 1'b1, 7'(bpos(5))}));
    reg_read(4'd4, v); chk("R8 data low", 64'(v), 64'(val[31:0] ^ 32'h20));
    reg_read(4'd5, v); chk("R8 data high", 64'(v), 64'(val[63:32]));
    mem_write(4, ~val);
    chk("R4 next write clean", mem_d[4], ~val);
  endtask

  task automatic t_hold_clear;
    logic [63:0] d; logic u; logic [31:0] v;
    reg_write(4'd0, 32'h0000_0703);
    mem_write(5, 64'h5555_0000_AAAA_1111);
    mem_read(5, 1'b0, 4'd3, 1'b0, d, u);
    reg_read(4'd2, v); chk("R9 first error held", 64'(v), 64'h3);
    reg_write(4'd1, 32'h1);
    reg_read(4'd1, v); chk("R9 w1c clears", 64'(v), 64'h0);
    mem_read(5, 1'b0, 4'd3, 1'b0, d, u);
    reg_read(4'd2, v); chk("R9 recapture addr", 64'(v), 64'h5);
    reg_read(4'd3, v); chk("R9 recapture bit", 64'(v[15:0]), 64'({8'd7, 1'b1, 7'(bpos(7))}));
    reg_write(4'd1, 32'h1);
  endtask

  task automatic t_multi;
    logic [63:0] d; logic u; logic [31:0] v;
    logic [63:0] val = 64'h1357_9BDF_2468_ACE0;
    logic [63:0] bad = val ^ (64'h1 << 3) ^ (64'h1 << 40);
    reg_write(4'd0, 32'h0028_0307);
    mem_write(6, val);
    chk("R3 multi wins, two flips", mem_d[6], bad);
    mem_read(6, 1'b1, 4'd2, 1'b0, d, u);
    chk("R7 raw data", d, bad);
    chk("R7 uncorr flag", 64'(u), 64'h1);
    reg_read(4'd1, v); chk("R7 multi status", 64'(v), 64'h2);
    reg_read(4'd6, v); chk("R8 multi addr", 64'(v), 64'h6);
    reg_read(4'd7, v);
    chk("R8 multi info", 64'(v),
        64'({4'b0, 8'd2, 1'b0, 1'b1, 2'd3, 8'd0, 1'b0, 7'(bpos(3) ^ bpos(40))}));
    reg_write(4'd1, 32'h3);
  endtask

  task automatic t_continuous;
    logic [63:0] d; logic u; logic [31:0] v;
    reg_write(4'd0, 32'h0000_0009);
    mem_write(7, 64'hAAAA);
    mem_write(8, 64'hBBBB);
    chk("R5 first write flipped", mem_d[7], 64'hAAAB);
    chk("R5 second write flipped", mem_d[8], 64'hBBBA);
    reg_read(4'd0, v); chk("R5 continuous stays", 64'(v), 64'h9);
    mem_read(8, 1'b0, 4'd0, 1'b0, d, u);
    chk("R6 continuous corrected", d, 64'hBBBB);
    reg_write(4'd0, 32'h0000_4003);
    mem_write(9, 64'hCCCC);
    chk("R3 position out of range", mem_d[9], 64'hCCCC);
    reg_write(4'd1, 32'h3);
  endtask

  task automatic t_disabled;
    logic [63:0] d; logic u; logic [31:0] v;
    reg_write(4'd0, 32'h0000_0102);
    mem_write(10, 64'hF0F0);
    mem_read(10, 1'b0, 4'd0, 1'b0, d, u);
    chk("R10 raw data", d, 64'hF0F2);
    chk("R10 no uncorr", 64'(u), 64'h0);
    reg_read(4'd1, v); chk("R10 no status", 64'(v), 64'h0);
    reg_write(4'd0, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_clean();
    t_single_oneshot();
    t_hold_clear();
    t_multi();
    t_continuous();
    t_disabled();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule